// File: doc/BRIEF.md
# Module Power and Reset Sequencer

This block sits on the host side of a board and controls the power of an attached radio module. It drives four signals: the enable of the battery rail, the enable of the I/O rail, the module enable, and the active-low module reset. A one-cycle power-up request walks these signals up in a fixed order. A one-cycle power-down request walks them down in the mirror order. Every step lasts for a tick count that the host programs, so the gaps between edges can be tuned to the board.

The gap between the module enable rising and the reset being released lets the module's crystal oscillator settle. That gap is floored in hardware. It cannot be programmed shorter than a parameterised number of microseconds, converted into clock ticks from the clock rate. An optional rail-good input holds the two rail steps until the supplies are reported as good. A ready output tells the host when the module is fully up.

Top module: `modpwr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the four drive outputs and `ready_o` are all low. The sequencer then rests in its off step.
- R2: `vio_en_o` is never high unless `vbat_en_o` is high. The I/O rail therefore never rises before the battery rail and never outlives it.
- R3: `mod_en_o` is never high unless `vio_en_o` is high.
- R4: `mod_rst_n_o` is never high unless `mod_en_o` is high. Reset is released only after the enable rises, and the two may fall together.
- R5: `mod_en_o` stays high with reset held low for max(`dly_settle_i`, MIN)+1 cycles before reset is released. MIN = ceil(CLK_HZ·SETTLE_US/10^6).
- R6: Written as {vbat,vio,en,rst_n}, the outputs step up through 1000, 1100, 1110, 1111 and then down through 1100, 1000, 0000. Each step other than the settle step lasts its programmed delay plus one cycle. The power-up delays are `dly_bat_io_i` and `dly_io_en_i`. The power-down delays are `dly_en_io_i` and `dly_io_bat_i`. A delay is sampled in the cycle its step is entered.
- R7: When USE_RAIL_GOOD is 1, the 1000 and 1100 power-up steps are held for as long as `rail_good_i` is low. Each step ends in the first cycle where its delay has expired and `rail_good_i` is high.
- R8: `ready_o` is high exactly when all four drive outputs are high.
- R9: A `down_req_i` during a power-up step aborts it in the next cycle. From the settle step (1110) the outputs go to 1100. From the 1100 step they go to the 1000 step that drops the battery rail. From the 1000 step they go straight to 0000.
- R10: `up_req_i` has no effect during the power-down steps or while fully up. `down_req_i` has no effect while off.
- R11: The module enable and module reset outputs always carry a known 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_i | input | 1 | Power-up request pulse |
| down_req_i | input | 1 | Power-down request pulse |
| rail_good_i | input | 1 | Supplies reported good (used when USE_RAIL_GOOD=1) |
| dly_bat_io_i | input | CNT_W | Ticks from battery rail up to I/O rail up |
| dly_io_en_i | input | CNT_W | Ticks from I/O rail up to module enable |
| dly_settle_i | input | CNT_W | Requested ticks from enable to reset release (floored at MIN) |
| dly_en_io_i | input | CNT_W | Ticks from enable/reset low to I/O rail down |
| dly_io_bat_i | input | CNT_W | Ticks from I/O rail down to battery rail down |
| vbat_en_o | output | 1 | Battery rail enable |
| vio_en_o | output | 1 | I/O rail enable |
| mod_en_o | output | 1 | Module enable |
| mod_rst_n_o | output | 1 | Module reset, active low |
| ready_o | output | 1 | Module fully powered and out of reset |

## Verification
The bench builds the block with CLK_HZ=1000, SETTLE_US=5000 and CNT_W=4, which gives a settle floor of 5 ticks, and with the rail-good gate enabled. With these values the full range of settle requests below and above the floor can be swept. Every combination of the four other step delays from 0 to 2 is crossed with settle requests 0 to 7, giving full up/down cycles whose step lengths are computed arithmetically. Short directed runs cover aborts from each power-up step, ignored requests, a held rail-good and reset in mid-run.

// File: rtl/modpwr_pkg.sv
package modpwr_pkg;

  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_BAT    = 3'd1,
    PS_IO     = 3'd2,
    PS_EN     = 3'd3,
    PS_RUN    = 3'd4,
    PS_EN_DN  = 3'd5,
    PS_IO_DN  = 3'd6
  } pstate_t;

  typedef struct packed {
    logic bat;
    logic io;
    logic en;
    logic rls;
    logic rdy;
  } drive_t;

  // Output levels held in each step.
  function automatic drive_t drive_of(pstate_t s);
    drive_t d;
    d = '0;
    case (s)
      PS_BAT:   d.bat = 1'b1;
      PS_IO:    begin d.bat = 1'b1; d.io = 1'b1; end
      PS_EN:    begin d.bat = 1'b1; d.io = 1'b1; d.en = 1'b1; end
      PS_RUN:   begin d.bat = 1'b1; d.io = 1'b1; d.en = 1'b1; d.rls = 1'b1; d.rdy = 1'b1; end
      PS_EN_DN: begin d.bat = 1'b1; d.io = 1'b1; end
      PS_IO_DN: d.bat = 1'b1;
      default:  d = '0;
    endcase
    return d;
  endfunction

  // Crystal settle floor in clock ticks, rounded up.
  function automatic longint unsigned settle_ticks(longint unsigned hz,
                                                   longint unsigned us);
    return (hz * us + 64'd999999) / 64'd1000000;
  endfunction

endpackage

// File: rtl/modpwr_timer.sv
module modpwr_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/modpwr_fsm.sv
module modpwr_fsm
  import modpwr_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req,
  input  logic             down_req,
  input  logic             rail_ok,
  input  logic             step_done,
  input  logic [CNT_W-1:0] dly_bat_io,
  input  logic [CNT_W-1:0] dly_io_en,
  input  logic [CNT_W-1:0] dly_settle,
  input  logic [CNT_W-1:0] dly_en_io,
  input  logic [CNT_W-1:0] dly_io_bat,
  output pstate_t          state,
  output pstate_t          state_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  pstate_t state_q;

  always_comb begin
    state_nxt = state_q;
    load      = 1'b0;
    load_val  = '0;
    case (state_q)
      PS_OFF: begin
        if (up_req) begin
          state_nxt = PS_BAT;
          load      = 1'b1;
          load_val  = dly_bat_io;
        end
      end
      PS_BAT: begin
        if (down_req) begin
          state_nxt = PS_OFF;
        end else if (step_done && rail_ok) begin
          state_nxt = PS_IO;
          load      = 1'b1;
          load_val  = dly_io_en;
        end
      end
      PS_IO: begin
        if (down_req) begin
          state_nxt = PS_IO_DN;
          load      = 1'b1;
          load_val  = dly_io_bat;
        end else if (step_done && rail_ok) begin
          state_nxt = PS_EN;
          load      = 1'b1;
          load_val  = dly_settle;
        end
      end
      PS_EN: begin
        if (down_req) begin
          state_nxt = PS_EN_DN;
          load      = 1'b1;
          load_val  = dly_en_io;
        end else if (step_done) begin
          state_nxt = PS_RUN;
        end
      end
      PS_RUN: begin
        if (down_req) begin
          state_nxt = PS_EN_DN;
          load      = 1'b1;
          load_val  = dly_en_io;
        end
      end
      PS_EN_DN: begin
        if (step_done) begin
          state_nxt = PS_IO_DN;
          load      = 1'b1;
          load_val  = dly_io_bat;
        end
      end
      PS_IO_DN: begin
        if (step_done) begin
          state_nxt = PS_OFF;
        end
      end
      default: state_nxt = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
    end else begin
      state_q <= state_nxt;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/modpwr_outreg.sv
module modpwr_outreg
  import modpwr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_t state_nxt,
  output drive_t  drive
);

  drive_t drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
    end else begin
      drive_q <= drive_of(state_nxt);
    end
  end

  assign drive = drive_q;

endmodule

// File: rtl/modpwr_seq.sv
module modpwr_seq
  import modpwr_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned SETTLE_US     = 5000,
  parameter int unsigned CNT_W         = 20,
  parameter bit          USE_RAIL_GOOD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req_i,
  input  logic             down_req_i,
  input  logic             rail_good_i,
  input  logic [CNT_W-1:0] dly_bat_io_i,
  input  logic [CNT_W-1:0] dly_io_en_i,
  input  logic [CNT_W-1:0] dly_settle_i,
  input  logic [CNT_W-1:0] dly_en_io_i,
  input  logic [CNT_W-1:0] dly_io_bat_i,
  output logic             vbat_en_o,
  output logic             vio_en_o,
  output logic             mod_en_o,
  output logic             mod_rst_n_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] SETTLE_MIN = CNT_W'(settle_ticks(CLK_HZ, SETTLE_US));

  function automatic logic [CNT_W-1:0] floor_settle(input logic [CNT_W-1:0] req);
    return (req < SETTLE_MIN) ? SETTLE_MIN : req;
  endfunction

  // Named internal events, visible to the bound checker.
  logic             step_done;
  logic             rail_ok;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] settle_eff;
  pstate_t          cur_state;
  pstate_t          nxt_state;
  drive_t           drv;

  generate
    if (USE_RAIL_GOOD) begin : g_rail
      assign rail_ok = rail_good_i;
    end else begin : g_norail
      assign rail_ok = 1'b1;
    end
  endgenerate

  assign settle_eff = floor_settle(dly_settle_i);

  modpwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (step_done)
  );

  modpwr_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_req     (up_req_i),
    .down_req   (down_req_i),
    .rail_ok    (rail_ok),
    .step_done  (step_done),
    .dly_bat_io (dly_bat_io_i),
    .dly_io_en  (dly_io_en_i),
    .dly_settle (settle_eff),
    .dly_en_io  (dly_en_io_i),
    .dly_io_bat (dly_io_bat_i),
    .state      (cur_state),
    .state_nxt  (nxt_state),
    .load       (tmr_load),
    .load_val   (tmr_val)
  );

  modpwr_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_nxt (nxt_state),
    .drive     (drv)
  );

  assign vbat_en_o   = drv.bat;
  assign vio_en_o    = drv.io;
  assign mod_en_o    = drv.en;
  assign mod_rst_n_o = drv.rls;
  assign ready_o     = drv.rdy;

endmodule

// File: rtl/modpwr_seq_chk.sv
module modpwr_seq_chk
  import modpwr_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned SETTLE_US = 5000
) (
  input logic    clk,
  input logic    rst_n,
  input logic    down_req,
  input logic    vbat_en,
  input logic    vio_en,
  input logic    mod_en,
  input logic    mod_rst_n,
  input logic    ready,
  input logic    step_done,
  input pstate_t cur_state
);

  localparam logic [31:0] MIN_TICKS = 32'(settle_ticks(CLK_HZ, SETTLE_US));

  // Consecutive cycles with enable high and reset still held.
  logic [31:0] hold_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (mod_en && !mod_rst_n) begin
      if (hold_cnt != 32'hFFFF_FFFF) hold_cnt <= hold_cnt + 1'b1;
    end else begin
      hold_cnt <= '0;
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !(vbat_en || vio_en || mod_en || mod_rst_n || ready));

  // R2
  io_needs_bat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vio_en |-> vbat_en);

  // R3
  en_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |-> vio_en);

  // R4
  rls_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_n |-> mod_en);

  // R5
  settle_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_rst_n) |-> (hold_cnt > MIN_TICKS));

  // R5
  settle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == PS_EN && step_done && !down_req) |=> mod_rst_n);

  // R8
  ready_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready == (vbat_en && vio_en && mod_en && mod_rst_n));

  // R9
  settle_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !mod_rst_n && down_req) |=> (!mod_en && !mod_rst_n && vio_en));

  // R11
  known_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({mod_en, mod_rst_n}));

endmodule

bind modpwr_seq modpwr_seq_chk #(
  .CLK_HZ    (CLK_HZ),
  .SETTLE_US (SETTLE_US)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .down_req  (down_req_i),
  .vbat_en   (vbat_en_o),
  .vio_en    (vio_en_o),
  .mod_en    (mod_en_o),
  .mod_rst_n (mod_rst_n_o),
  .ready     (ready_o),
  .step_done (step_done),
  .cur_state (cur_state)
);

// File: tb/modpwr_seq_tb.sv
module modpwr_seq_tb;

  localparam int CW    = 4;
  localparam int FLOOR = 5;   // ceil(1000 * 5000 / 1e6)

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up_req = 1'b0, down_req = 1'b0, rail_good = 1'b1;
  logic [CW-1:0] d_bi = '0, d_ie = '0, d_st = '0, d_ei = '0, d_ib = '0;
  logic          vbat, vio, men, mrst_n, rdy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  modpwr_seq #(
    .CLK_HZ(1000), .SETTLE_US(5000), .CNT_W(CW), .USE_RAIL_GOOD(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .up_req_i(up_req), .down_req_i(down_req),
    .rail_good_i(rail_good), .dly_bat_io_i(d_bi), .dly_io_en_i(d_ie),
    .dly_settle_i(d_st), .dly_en_io_i(d_ei), .dly_io_bat_i(d_ib),
    .vbat_en_o(vbat), .vio_en_o(vio), .mod_en_o(men), .mod_rst_n_o(mrst_n),
    .ready_o(rdy)
  );

  function automatic logic [3:0] pat();
    return {vbat, vio, men, mrst_n};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Ordering and ready checks on every cycle (R2 R3 R4 R8 R11).
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(!vio || vbat,    "R2", int'(pat()), 4'b1000);
      chk(!men || vio,     "R3", int'(pat()), 4'b1100);
      chk(!mrst_n || men,  "R4", int'(pat()), 4'b1110);
      chk(rdy == (pat() == 4'b1111), "R8", int'(rdy), int'(pat() == 4'b1111));
      chk(!$isunknown({men, mrst_n}), "R11", int'({men, mrst_n}), 0);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      report();
    end
  end

  task automatic run_len(input logic [3:0] p, output int n);
    n = 0;
    while (pat() == p && n < 60) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_up();
    up_req = 1'b1; @(negedge clk); up_req = 1'b0;
  endtask

  task automatic pulse_down();
    down_req = 1'b1; @(negedge clk); down_req = 1'b0;
  endtask

  task automatic full_cycle(input int a, input int b, input int c, input int d, input int e);
    int n;
    int st;
    d_bi = CW'(a); d_ie = CW'(b); d_st = CW'(c); d_ei = CW'(d); d_ib = CW'(e);
    st = (c < FLOOR) ? FLOOR : c;
    pulse_up();
    run_len(4'b1000, n); chk(n == a + 1, "R6 bat step", n, a + 1);
    run_len(4'b1100, n); chk(n == b + 1, "R6 io step", n, b + 1);
    run_len(4'b1110, n); chk(n == st + 1, "R5 settle", n, st + 1);
    chk(pat() == 4'b1111 && rdy, "R6 run", int'(pat()), 4'b1111);
    pulse_up();  // R10: ignored while fully up
    chk(pat() == 4'b1111, "R10 up in run", int'(pat()), 4'b1111);
    pulse_down();
    run_len(4'b1100, n); chk(n == d + 1, "R6 en down", n, d + 1);
    run_len(4'b1000, n); chk(n == e + 1, "R6 io down", n, e + 1);
    chk(pat() == 4'b0000, "R6 off", int'(pat()), 0);
  endtask

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({pat(), rdy} == 5'b0, "R1 in reset", int'({pat(), rdy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pat(), rdy} == 5'b0, "R1 after reset", int'({pat(), rdy}), 0);

    // R10: power-down request while off
    pulse_down();
    repeat (3) @(negedge clk);
    chk(pat() == 4'b0000, "R10 down in off", int'(pat()), 0);

    // Sweep: R5 R6
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int d = 0; d < 3; d++)
          for (int e = 0; e < 3; e++)
            for (int c = 0; c < 8; c++) begin
              full_cycle(a, b, c, d, e);
              @(negedge clk);
            end

    // R9: abort during settle step
    d_bi = 0; d_ie = 0; d_st = 9; d_ei = 2; d_ib = 1;
    pulse_up();
    run_len(4'b1000, n);
    run_len(4'b1100, n);
    @(negedge clk); @(negedge clk);
    pulse_down();
    chk(pat() == 4'b1100, "R9 abort settle", int'(pat()), 4'b1100);
    run_len(4'b1100, n); chk(n == 3, "R9 abort settle down", n, 3);
    run_len(4'b1000, n); chk(n == 2 && pat() == 0, "R9 abort settle off", n, 2);

    // R9: abort during battery step
    d_bi = 6;
    pulse_up();
    @(negedge clk);
    pulse_down();
    chk(pat() == 4'b0000, "R9 abort bat", int'(pat()), 0);

    // R9: abort during io step
    d_bi = 0; d_ie = 6; d_ib = 3;
    pulse_up();
    run_len(4'b1000, n);
    chk(pat() == 4'b1100, "R9 io entered", int'(pat()), 4'b1100);
    pulse_down();
    run_len(4'b1000, n); chk(n == 4, "R9 abort io", n, 4);
    chk(pat() == 4'b0000, "R9 abort io off", int'(pat()), 0);

    // R7: rail-good holds the rail steps
    d_bi = 0; d_ie = 0; d_st = 0; d_ei = 4; d_ib = 0;
    rail_good = 1'b0;
    pulse_up();
    repeat (8) @(negedge clk);
    chk(pat() == 4'b1000, "R7 bat held", int'(pat()), 4'b1000);
    rail_good = 1'b1;
    @(negedge clk);
    chk(pat() == 4'b1100, "R7 bat released", int'(pat()), 4'b1100);
    rail_good = 1'b0;
    repeat (6) @(negedge clk);
    chk(pat() == 4'b1100, "R7 io held", int'(pat()), 4'b1100);
    rail_good = 1'b1;
    @(negedge clk);
    chk(pat() == 4'b1110, "R7 io released", int'(pat()), 4'b1110);
    run_len(4'b1110, n); chk(n == FLOOR + 1, "R5 floor", n, FLOOR + 1);

    // R10: power-up request during power-down is ignored
    pulse_down();
    @(negedge clk);
    pulse_up();
    run_len(4'b1100, n);
    run_len(4'b1000, n);
    repeat (4) @(negedge clk);
    chk(pat() == 4'b0000, "R10 up in power-down", int'(pat()), 0);

    // R1: reset in mid-run
    d_st = 0;
    pulse_up();
    repeat (12) @(negedge clk);
    chk(pat() == 4'b1111, "R6 up again", int'(pat()), 4'b1111);
    rst_n = 1'b0;
    #1;
    chk({pat(), rdy} == 5'b0, "R1 mid-run reset", int'({pat(), rdy}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pat() == 4'b0000, "R1 off after reset", int'(pat()), 0);

    report();
  end

endmodule